// File: doc/BRIEF.md
# Four-Lane Clock-Master Audio Serializer

This block turns parallel audio samples into four serial data lines that share one bit clock and one word-select clock, both generated here from the system clock. Each line carries a stereo pair, so the four lines together carry eight channels. A producer hands over one complete set of four left/right sample pairs through a valid/ready handshake. The block adopts that set at the next frame boundary, which is the start of a left half-frame, and repeats the set in use whenever nothing new has arrived.

Every half-frame spans 32 bit-clock periods. The word select is low for the left half and high for the right half. The word length and the alignment can be selected while the block runs. The alignment choices are standard I2S (MSB one bit clock after the word-select edge), left-justified (MSB on the edge) and right-justified (LSB in the last slot of the half). In every alignment the MSB is sent first. Word select and data only ever change on the clock edge where the bit clock falls.

Top module: `audio_quad_serializer`

## Requirements
- R1: The bit clock is low from reset and toggles every SCLK_HALF system clocks, giving a period of 2*SCLK_HALF clocks at 50% duty.
- R2: The word select and all data lines change only on a system clock edge at which the bit clock falls.
- R3: A frame is 64 bit-clock slots. The word select is low for slots 0..31 (left) and high for slots 32..63 (right).
- R4: With fmt_sel=1 (left-justified), the MSB of a word is driven in slot 0 of its half, the same slot in which the word select changes. The other bits follow MSB first.
- R5: With fmt_sel=0 (I2S; code 3 behaves the same), each data line carries the left-justified stream delayed by exactly one bit-clock period.
- R6: With fmt_sel=2 (right-justified), the word occupies the last W slots of its half and its LSB falls in slot 31 of the half.
- R7: The word length W is selected by wlen_sel: 0=16, 1=20, 2=24, 3=32 bits, taken from bits W-1..0 of each sample field. Slots not holding word bits are driven low, and sample bits at or above W have no effect on the outputs.
- R8: in_ready is high while the holding stage is empty. A set offered with in_valid while in_ready is high is accepted on that clock, and in_ready then stays low until that set is adopted at the next frame start.
- R9: If no new set was accepted before a frame start, the previous samples are sent again unchanged.
- R10: Lane n sends bits [32n+31:32n] of in_left and in_right. All lanes share the bit clock and word select and are framed identically.
- R11: After reset the bit clock, word select and all data lines are low, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Alignment: 0 I2S, 1 left-justified, 2 right-justified, 3 as I2S |
| wlen_sel | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Holding stage empty, offer will be taken |
| in_left | input | LANES*32 | Left samples, 32-bit field per lane |
| in_right | input | LANES*32 | Right samples, 32-bit field per lane |
| sclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word select, low = left |
| sd_o | output | LANES | Serial data, one line per stereo pair |

## Verification
The bench attacks the slot arithmetic at its edges. A 32-bit word in I2S mode must spill its LSB into slot 0 of the next half; an off-by-one delay would instead drop or duplicate that bit. A 16-bit right-justified word must start exactly 16 slots into the half; a wrong offset would shift the whole word or clip its LSB. A 20-bit word is sent with junk in its upper bits, so a design that fails to mask those bits leaks ones into the zero slots. The bench also offers sets back to back and then stops offering: a design that adopts a set mid-frame, drops the second set, or clears the samples when starved shows a wrong bit on some lane.

// File: rtl/aqs_pkg.sv
// Shared constants, types and slot/bit mapping helpers for the
// four-lane audio serializer. Assumes a fixed 32-slot half-frame.
package aqs_pkg;

    localparam int SLOT_BITS  = 32;
    localparam int FRAME_SLOT = 2 * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_SLOT);
    localparam int SLOT_IDX_W = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_ALT   = 2'd3
    } fmt_e;

    typedef logic [SLOT_BITS-1:0] word_t;

    // Translate the word-length code into a bit count.
    function automatic int word_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

    // Bit sent in slot p when the word starts in slot 0 (MSB first).
    function automatic logic msb_first_bit(input word_t w, input int p, input int bits);
        if (p < bits) return w[bits - 1 - p];
        return 1'b0;
    endfunction

    // Bit sent in slot p when the word ends in the last slot.
    function automatic logic lsb_last_bit(input word_t w, input int p, input int bits);
        if (p >= SLOT_BITS - bits) return w[SLOT_BITS - 1 - p];
        return 1'b0;
    endfunction

endpackage

// File: rtl/aqs_timing.sv
// Bit-clock and frame timing generator.
// Divides the system clock into a 50% bit clock, flags the system clock
// edges where the bit clock falls, and tracks the frame slot being driven.
// Assumes SCLK_HALF >= 1.
module aqs_timing
    import aqs_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sclk_o,
    output logic             lrclk_o,
    output logic             fall_tick,
    output logic             frame_wrap,
    output logic [POS_W-1:0] pos_next
);

    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);

    logic [DIV_W-1:0] div_q;
    logic             sclk_q;
    logic [POS_W-1:0] pos_q;
    logic             lr_q;
    logic             half_done;

    assign half_done  = (div_q == DIV_LAST);
    assign fall_tick  = half_done && sclk_q;
    assign pos_next   = pos_q + POS_W'(1);
    assign frame_wrap = fall_tick && (&pos_q);

    // Count system clocks within one bit-clock half period.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= '0;
        else if (half_done) div_q <= '0;
        else                div_q <= div_q + DIV_W'(1);
    end

    // Toggle the bit clock at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n)         sclk_q <= 1'b0;
        else if (half_done) sclk_q <= ~sclk_q;
    end

    // Advance the slot position and word select on each falling bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            lr_q  <= 1'b0;
        end else if (fall_tick) begin
            pos_q <= pos_next;
            lr_q  <= pos_next[POS_W-1];
        end
    end

    assign sclk_o  = sclk_q;
    assign lrclk_o = lr_q;

    generate
        if (SCLK_HALF > 1) begin : g_hold_chk
            // R1: after a bit-clock toggle, the level holds for the next clock.
            assert_sclk_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(sclk_q) |=> $stable(sclk_q));
        end
    endgenerate

    // R3: the word select rises only when the right half starts.
    assert_lr_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lr_q) |-> (pos_q == POS_W'(SLOT_BITS)));

    // R3: the word select falls only at the frame start.
    assert_lr_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lr_q) |-> (pos_q == '0));

endmodule

// File: rtl/aqs_sample_buf.sv
// Two-stage sample store: a holding stage filled through a valid/ready
// handshake, and an active stage that the lanes read. The holding stage
// moves into the active stage only at a frame start; otherwise the
// active stage keeps its contents, so a starved frame repeats.
module aqs_sample_buf
    import aqs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [LANES*SLOT_BITS-1:0] in_left,
    input  logic [LANES*SLOT_BITS-1:0] in_right,
    input  logic                       frame_wrap,
    output logic [LANES*SLOT_BITS-1:0] act_left_next,
    output logic [LANES*SLOT_BITS-1:0] act_right_next
);

    logic [LANES*SLOT_BITS-1:0] hold_left, hold_right;
    logic [LANES*SLOT_BITS-1:0] act_left, act_right;
    logic                       hold_full;
    logic                       take;
    logic                       adopt;

    assign in_ready = !hold_full;
    assign take     = in_valid && !hold_full;
    assign adopt    = frame_wrap && hold_full;

    // Pick what the active stage holds after this clock, for same-edge use.
    always_comb begin
        act_left_next  = adopt ? hold_left  : act_left;
        act_right_next = adopt ? hold_right : act_right;
    end

    // Track whether the holding stage carries an unadopted set.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_full <= 1'b0;
        else if (take)  hold_full <= 1'b1;
        else if (adopt) hold_full <= 1'b0;
    end

    // Capture an offered set into the holding stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_left  <= '0;
            hold_right <= '0;
        end else if (take) begin
            hold_left  <= in_left;
            hold_right <= in_right;
        end
    end

    // Load the active stage at the frame start when a set is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_left  <= '0;
            act_right <= '0;
        end else begin
            act_left  <= act_left_next;
            act_right <= act_right_next;
        end
    end

    // R8: an accepted offer closes the handshake until adoption.
    assert_take_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R9: the active samples never change away from a frame start.
    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> ($stable(act_left) && $stable(act_right)));

endmodule

// File: rtl/aqs_lane.sv
// One serial data lane. On each falling bit-clock edge it drives the bit
// for the slot that edge starts. The bit is chosen from the left or right
// word by the half-frame and placed by the selected alignment. I2S output
// is the left-justified stream delayed one slot through a one-bit register.
module aqs_lane
    import aqs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_tick,
    input  logic [POS_W-1:0] pos_next,
    input  logic [1:0]       fmt_sel,
    input  logic [1:0]       wlen_sel,
    input  word_t            word_l,
    input  word_t            word_r,
    output logic             sd_o
);

    int    slot;
    int    bits;
    word_t word;
    logic  lj_bit;
    logic  rj_bit;
    logic  lj_prev;
    logic  sd_q;
    fmt_e  fmt;

    // Resolve the word, slot and candidate bits for the coming slot.
    always_comb begin
        fmt    = fmt_e'(fmt_sel);
        slot   = int'(pos_next[SLOT_IDX_W-1:0]);
        bits   = word_bits(wlen_sel);
        word   = pos_next[POS_W-1] ? word_r : word_l;
        lj_bit = msb_first_bit(word, slot, bits);
        rj_bit = lsb_last_bit(word, slot, bits);
    end

    // Keep the last left-justified bit for the one-slot I2S delay.
    always_ff @(posedge clk) begin
        if (!rst_n)         lj_prev <= 1'b0;
        else if (fall_tick) lj_prev <= lj_bit;
    end

    // Drive the line for the new slot per the selected alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) sd_q <= 1'b0;
        else if (fall_tick) begin
            case (fmt)
                FMT_LEFT:  sd_q <= lj_bit;
                FMT_RIGHT: sd_q <= rj_bit;
                default:   sd_q <= lj_prev;
            endcase
        end
    end

    assign sd_o = sd_q;

    // R7: in right-justified mode, slots ahead of the word carry zero.
    assert_rj_pad_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_tick && fmt == FMT_RIGHT && slot < SLOT_BITS - bits) |=> !sd_q);

endmodule

// File: rtl/audio_quad_serializer.sv
// Four-lane clock-master audio serializer top level.
// Generates the shared bit clock and word select, holds one set of
// left/right samples per frame, and drives one serial line per lane.
// Assumes samples occupy the low wlen bits of each 32-bit field.
module audio_quad_serializer
    import aqs_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int SCLK_HALF = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 fmt_sel,
    input  logic [1:0]                 wlen_sel,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [LANES*SLOT_BITS-1:0] in_left,
    input  logic [LANES*SLOT_BITS-1:0] in_right,
    output logic                       sclk_o,
    output logic                       lrclk_o,
    output logic [LANES-1:0]           sd_o
);

    logic                       fall_tick;
    logic                       frame_wrap;
    logic [POS_W-1:0]           pos_next;
    logic [LANES*SLOT_BITS-1:0] act_left_next;
    logic [LANES*SLOT_BITS-1:0] act_right_next;

    aqs_timing #(.SCLK_HALF(SCLK_HALF)) i_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_o     (sclk_o),
        .lrclk_o    (lrclk_o),
        .fall_tick  (fall_tick),
        .frame_wrap (frame_wrap),
        .pos_next   (pos_next)
    );

    aqs_sample_buf #(.LANES(LANES)) i_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_left        (in_left),
        .in_right       (in_right),
        .frame_wrap     (frame_wrap),
        .act_left_next  (act_left_next),
        .act_right_next (act_right_next)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            aqs_lane i_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .fall_tick (fall_tick),
                .pos_next  (pos_next),
                .fmt_sel   (fmt_sel),
                .wlen_sel  (wlen_sel),
                .word_l    (act_left_next[g*SLOT_BITS +: SLOT_BITS]),
                .word_r    (act_right_next[g*SLOT_BITS +: SLOT_BITS]),
                .sd_o      (sd_o[g])
            );
        end
    endgenerate

    // R2: the word select moves only with a falling bit clock.
    assert_lr_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk_o) |-> $fell(sclk_o));

    // R2: data lines move only with a falling bit clock.
    assert_sd_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_o) |-> $fell(sclk_o));

endmodule

// File: tb/test_audio_quad_serializer.sv
// Behavioural reference model of the serializer, compared on every clock.
module test_audio_quad_serializer;

    localparam int LANES = 4;
    localparam int HALF  = 2;
    localparam int W     = LANES * 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   fmt_sel = 2'd1;
    logic [1:0]   wlen_sel = 2'd3;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_left = '0;
    logic [W-1:0] in_right = '0;
    logic         sclk_o;
    logic         lrclk_o;
    logic [LANES-1:0] sd_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R11";
    bit    comparing = 0;
    bit    finished  = 0;

    // reference model state
    int          m_div, m_pos;
    bit          m_sclk, m_lr, m_full;
    logic [LANES-1:0] m_sd, m_prev;
    logic [31:0] m_hold_l [LANES];
    logic [31:0] m_hold_r [LANES];
    logic [31:0] m_act_l  [LANES];
    logic [31:0] m_act_r  [LANES];

    audio_quad_serializer #(.LANES(LANES), .SCLK_HALF(HALF)) i_audio_quad_serializer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_sel  (fmt_sel),
        .wlen_sel (wlen_sel),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .sclk_o   (sclk_o),
        .lrclk_o  (lrclk_o),
        .sd_o     (sd_o)
    );

    always #2.5 clk = ~clk;

    function automatic int wbits(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : (s == 2'd2) ? 24 : 32;
    endfunction

    // Slot bit per R4 (word at slot 0) and R6 (word ending at slot 31).
    function automatic logic ref_bit(input logic [31:0] w, input int p, input int n, input bit rj);
        int idx;
        idx = rj ? (p - (32 - n)) : p;
        if (idx < 0 || idx >= n) return 1'b0;
        return w[n - 1 - idx];
    endfunction

    // Reference model: advances once per system clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_sclk = 0; m_pos = 0; m_lr = 0; m_full = 0;
            m_sd = '0; m_prev = '0;
            for (int l = 0; l < LANES; l++) begin
                m_hold_l[l] = 0; m_hold_r[l] = 0; m_act_l[l] = 0; m_act_r[l] = 0;
            end
        end else begin
            bit take;
            take = in_valid && !m_full;
            if (m_div == HALF - 1) begin
                m_div = 0;
                if (m_sclk) begin
                    m_pos = (m_pos + 1) % 64;
                    if (m_pos == 0 && m_full) begin
                        for (int l = 0; l < LANES; l++) begin
                            m_act_l[l] = m_hold_l[l]; m_act_r[l] = m_hold_r[l];
                        end
                        m_full = 0;
                    end
                    m_lr = (m_pos >= 32);
                    for (int l = 0; l < LANES; l++) begin
                        logic [31:0] w;
                        logic lj, rj;
                        w  = m_lr ? m_act_r[l] : m_act_l[l];
                        lj = ref_bit(w, m_pos % 32, wbits(wlen_sel), 0);
                        rj = ref_bit(w, m_pos % 32, wbits(wlen_sel), 1);
                        m_sd[l] = (fmt_sel == 2'd1) ? lj : (fmt_sel == 2'd2) ? rj : m_prev[l];
                        m_prev[l] = lj;
                    end
                end
                m_sclk = !m_sclk;
            end else begin
                m_div = m_div + 1;
            end
            if (take) begin
                for (int l = 0; l < LANES; l++) begin
                    m_hold_l[l] = in_left[l*32 +: 32]; m_hold_r[l] = in_right[l*32 +: 32];
                end
                m_full = 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every clock away from the active edge; also watch change timing (R2).
    logic p_sclk, p_lr;
    logic [LANES-1:0] p_sd;
    always @(negedge clk) begin
        if (comparing) begin
            check(sclk_o == m_sclk, "R1", "sclk", sclk_o, m_sclk);
            check(lrclk_o == m_lr, "R3", "lrclk", lrclk_o, m_lr);
            check(sd_o == m_sd, tag, "sd", sd_o, m_sd);
            check(in_ready == !m_full, "R8", "ready", in_ready, !m_full);
            if (lrclk_o != p_lr || sd_o != p_sd)
                check(p_sclk && !sclk_o, "R2", "change without sclk fall", sclk_o, 0);
        end
        p_sclk = sclk_o; p_lr = lrclk_o; p_sd = sd_o;
    end

    function automatic logic [31:0] pat(input int lane, input int side, input int seed);
        return 32'h9E3779B9 * (lane + 1) ^ (side ? 32'hC3A50F96 : 32'h5A0FF01E) ^ (seed * 32'h01010101);
    endfunction

    task automatic send(input int seed);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            in_left[l*32 +: 32]  = pat(l, 0, seed);
            in_right[l*32 +: 32] = pat(l, 1, seed);
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic frames(input int n);
        repeat (n * 64 * 2 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset values
        check(sclk_o == 0, "R11", "sclk in reset", sclk_o, 0);
        check(lrclk_o == 0, "R11", "lrclk in reset", lrclk_o, 0);
        check(sd_o == 0, "R11", "sd in reset", sd_o, 0);
        check(in_ready == 1, "R11", "ready in reset", in_ready, 1);
        rst_n = 1'b1;
        comparing = 1;

        // R4, R8: left-justified 32-bit, two sets back to back
        tag = "R4"; fmt_sel = 2'd1; wlen_sel = 2'd3;
        send(1); send(2);
        check(in_ready == 0, "R8", "ready while set pending", in_ready, 0);
        frames(3);

        // R5: I2S 24-bit, then 32-bit so the LSB spills into the next half
        tag = "R5"; fmt_sel = 2'd0; wlen_sel = 2'd2;
        send(3); frames(2);
        wlen_sel = 2'd3; send(4); frames(2);
        tag = "R5"; fmt_sel = 2'd3; frames(1);

        // R6: right-justified 16-bit and 24-bit
        tag = "R6"; fmt_sel = 2'd2; wlen_sel = 2'd0;
        send(5); frames(2);
        wlen_sel = 2'd2; send(6); frames(2);

        // R7: 20-bit words carrying junk above bit 19
        tag = "R7"; fmt_sel = 2'd1; wlen_sel = 2'd1;
        send(7); frames(2);
        fmt_sel = 2'd2; frames(1);

        // R9: starved frames repeat the last set
        tag = "R9"; fmt_sel = 2'd1; wlen_sel = 2'd3;
        frames(3);

        // R10: distinct per-lane content under I2S 32-bit
        tag = "R10"; fmt_sel = 2'd0;
        send(8); frames(2);

        comparing = 0;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule